// File: doc/BRIEF.md
# Filler NAL Unit Streamer

This block produces one complete filler-data NAL unit whose total length in bytes is chosen by the caller. A one-cycle start pulse carries the requested length N. The block then sends, one byte per accepted transfer on a byte-wide valid/ready output, a four-byte start code, the two-byte unit header for the filler type, a run of 0xFF padding bytes, and a single stop byte. The padding run is sized so that exactly one byte is left for the stop byte, so the unit is always exactly N bytes long.

When N is too small to hold the start code, the header and the stop byte (fewer than 7 bytes), the block emits nothing and raises a one-cycle error pulse instead. After the stop byte is accepted, a one-cycle done pulse reports the number of bytes produced. The controller is a state machine with six states: IDLE (waiting for a start pulse), SYNC (start code), HDR (header), PAD (padding), STOP (stop byte) and DONE (completion report). Its transitions are: IDLE to SYNC on an accepted start; IDLE to IDLE with an error pulse on a rejected start; SYNC to HDR after the fourth start-code byte; HDR to PAD after the second header byte when N is above 7, or HDR to STOP when N is exactly 7; PAD to STOP once N-7 padding bytes have gone; STOP to DONE when the stop byte is accepted; DONE to IDLE unconditionally.

Top module: `fill_nal_gen`

## Requirements
- R1: The first four bytes of every unit are 0x00, 0x00, 0x00, 0x01, in that order.
- R2: Bytes five and six are the header 0x4C then 0x01 (forbidden bit 0, unit type 38, layer 0, temporal id plus one equal to 1, packed MSB first).
- R3: Bytes seven up to N-1 are all 0xFF, so the padding count is N-7 (zero when N is 7) and the unit has exactly N bytes.
- R4: The final byte is 0x80, and `out_last_o` is high with that byte and with no other byte.
- R5: A start with N below 7 produces a single-cycle `err_o` pulse in the next cycle, no output byte and no done pulse.
- R6: A byte advances only when `out_valid_o` and `out_ready_i` are both high; while valid is high and ready is low, valid stays high and the data stays unchanged.
- R7: In the cycle after the stop byte is accepted, `done_o` is high for exactly one cycle and `count_o` equals N.
- R8: A start pulse that arrives while a unit is in progress is ignored: the unit in progress keeps its length and no error is raised.
- R9: After reset the block is idle: `out_valid_o`, `out_last_o`, `busy_o`, `err_o` and `done_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin a unit |
| len_i | input | LEN_W | Requested total unit length N, sampled with `start_i` |
| out_valid_o | output | 1 | Output byte is valid |
| out_data_o | output | 8 | Output byte |
| out_ready_i | input | 1 | Downstream accepts the byte this cycle |
| out_last_o | output | 1 | Marks the stop byte |
| busy_o | output | 1 | A unit is being produced |
| err_o | output | 1 | One-cycle pulse: requested length too short |
| done_o | output | 1 | One-cycle pulse: unit complete |
| count_o | output | LEN_W | Bytes produced, valid while `done_o` is high |

## Verification
Assertions check on every cycle that a stalled byte is held with valid, that the last flag only accompanies the 0x80 stop byte, that an error pulse lasts one cycle and never overlaps output, that done follows the accepted stop byte and reports the latched length, and that the byte counter stays below N while bytes are offered. The exact byte sequence, the padding count for each length, the rejection of short lengths and the immunity to a start during a unit can only be shown by the bench, which sweeps every length from 0 to 40 plus a long unit under continuous, alternating and pseudo-random ready patterns and rebuilds the expected stream arithmetically from N.

// File: rtl/fill_nal_pkg.sv
package fill_nal_pkg;

    localparam int SYNC_BYTES = 4;
    localparam int HDR_BYTES  = 2;
    localparam int STOP_BYTES = 1;
    localparam int MIN_LEN    = SYNC_BYTES + HDR_BYTES + STOP_BYTES;

    localparam logic [5:0] FILL_TYPE   = 6'd38;
    localparam logic [5:0] LAYER_ID    = 6'd0;
    localparam logic [2:0] TID_PLUS1   = 3'd1;
    localparam logic [15:0] HDR_WORD   = {1'b0, FILL_TYPE, LAYER_ID, TID_PLUS1};

    localparam logic [7:0] PAD_BYTE    = 8'hFF;
    localparam logic [7:0] STOP_BYTE   = 8'h80;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_HDR,
        ST_PAD,
        ST_STOP,
        ST_DONE
    } gen_state_t;

endpackage

// File: rtl/fng_len_check.sv
module fng_len_check #(
    parameter int LEN_W = 16
) (
    input  logic [LEN_W-1:0] len_i,
    output logic             too_short_o,
    output logic             no_pad_o
);
    import fill_nal_pkg::*;

    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);

    always_comb begin
        too_short_o = (len_i < MIN_L);
        no_pad_o    = (len_i == MIN_L);
    end
endmodule

// File: rtl/fng_byte_sel.sv
module fng_byte_sel (
    input  fill_nal_pkg::gen_state_t state_i,
    input  logic [2:0]               idx_i,
    output logic [7:0]               byte_o
);
    import fill_nal_pkg::*;

    always_comb begin
        byte_o = 8'h00;
        unique case (state_i)
            ST_SYNC: byte_o = (idx_i == 3'(SYNC_BYTES - 1)) ? 8'h01 : 8'h00;
            ST_HDR:  byte_o = (idx_i == 3'(SYNC_BYTES)) ? HDR_WORD[15:8] : HDR_WORD[7:0];
            ST_PAD:  byte_o = PAD_BYTE;
            ST_STOP: byte_o = STOP_BYTE;
            ST_IDLE, ST_DONE: byte_o = 8'h00;
            default: byte_o = 8'h00;
        endcase
    end
endmodule

// File: rtl/fill_nal_gen.sv
module fill_nal_gen #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             out_valid_o,
    output logic [7:0]       out_data_o,
    input  logic             out_ready_i,
    output logic             out_last_o,
    output logic             busy_o,
    output logic             err_o,
    output logic             done_o,
    output logic [LEN_W-1:0] count_o
);
    import fill_nal_pkg::*;

    localparam logic [LEN_W-1:0] SYNC_END = LEN_W'(SYNC_BYTES - 1);
    localparam logic [LEN_W-1:0] HDR_END  = LEN_W'(SYNC_BYTES + HDR_BYTES - 1);

    gen_state_t       state_q, state_d;
    logic [LEN_W-1:0] sent_q;
    logic [LEN_W-1:0] len_q;
    logic             err_q;
    logic             start_short, start_bare_q, unused_nopad_in;
    logic             hs;
    logic             start_ok;

    // Length checks: one on the incoming request, one on the latched length.
    fng_len_check #(.LEN_W(LEN_W)) u_chk_in (
        .len_i       (len_i),
        .too_short_o (start_short),
        .no_pad_o    (unused_nopad_in)
    );

    logic unused_short_q;
    fng_len_check #(.LEN_W(LEN_W)) u_chk_q (
        .len_i       (len_q),
        .too_short_o (unused_short_q),
        .no_pad_o    (start_bare_q)
    );

    fng_byte_sel u_sel (
        .state_i (state_q),
        .idx_i   (sent_q[2:0]),
        .byte_o  (out_data_o)
    );

    assign hs       = out_valid_o && out_ready_i;
    assign start_ok = (state_q == ST_IDLE) && start_i && !start_short;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_ok) state_d = ST_SYNC;
            ST_SYNC: if (hs && sent_q == SYNC_END) state_d = ST_HDR;
            ST_HDR:  if (hs && sent_q == HDR_END)
                         state_d = start_bare_q ? ST_STOP : ST_PAD;
            ST_PAD:  if (hs && sent_q == len_q - LEN_W'(2)) state_d = ST_STOP;
            ST_STOP: if (hs) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sent_q  <= '0;
            len_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= (state_q == ST_IDLE) && start_i && start_short;
            if (start_ok) begin
                sent_q <= '0;
                len_q  <= len_i;
            end else if (hs) begin
                sent_q <= sent_q + LEN_W'(1);
            end
        end
    end

    // Moore outputs
    always_comb begin
        out_valid_o = 1'b0;
        out_last_o  = 1'b0;
        busy_o      = 1'b1;
        done_o      = 1'b0;
        unique case (state_q)
            ST_IDLE: busy_o = 1'b0;
            ST_SYNC, ST_HDR, ST_PAD: out_valid_o = 1'b1;
            ST_STOP: begin
                out_valid_o = 1'b1;
                out_last_o  = 1'b1;
            end
            ST_DONE: done_o = 1'b1;
            default: busy_o = 1'b0;
        endcase
    end

    assign err_o   = err_q;
    assign count_o = sent_q;

    // Assertions
    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

    p_last_is_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_last_o |-> (out_valid_o && out_data_o == STOP_BYTE));

    p_err_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!out_valid_o && !done_o));

    p_err_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    p_done_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_last_o && hs) |=> (done_o && count_o == len_q));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (sent_q < len_q));

    p_len_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(len_q));

endmodule

// File: tb/fill_nal_gen_test.sv
module fill_nal_gen_test;
    localparam int LEN_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [LEN_W-1:0] len_i = '0;
    logic             out_valid_o;
    logic [7:0]       out_data_o;
    logic             out_ready_i = 1'b0;
    logic             out_last_o;
    logic             busy_o;
    logic             err_o;
    logic             done_o;
    logic [LEN_W-1:0] count_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    fill_nal_gen #(.LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .out_valid_o(out_valid_o), .out_data_o(out_data_o),
        .out_ready_i(out_ready_i), .out_last_o(out_last_o),
        .busy_o(busy_o), .err_o(err_o), .done_o(done_o), .count_o(count_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (time %0t)", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int k, input int n);
        if (k < 3) return 8'h00;
        if (k == 3) return 8'h01;
        if (k == 4) return 8'h4C;
        if (k == 5) return 8'h01;
        if (k == n - 1) return 8'h80;
        return 8'hFF;
    endfunction

    function automatic string req_of(input int k, input int n);
        if (k < 4) return "R1";
        if (k < 6) return "R2";
        if (k == n - 1) return "R4";
        return "R3";
    endfunction

    task automatic run_unit(input int n, input int mode, input bit poke);
        int  k = 0;
        int  c = 0;
        bit  fin = 0;
        bit  stalled = 0;
        logic [7:0] held = 8'h00;
        bit  saw_err = 0;
        @(negedge clk);
        start_i = 1'b1;
        len_i   = LEN_W'(n);
        @(negedge clk);
        start_i = 1'b0;
        if (n < 7) begin
            #1;
            chk(err_o == 1'b1, "R5", int'(err_o), 1);
            chk(out_valid_o == 1'b0, "R5", int'(out_valid_o), 0);
            @(negedge clk); #1;
            chk(err_o == 1'b0 && done_o == 1'b0 && out_valid_o == 1'b0,
                "R5", int'({err_o, done_o, out_valid_o}), 0);
            return;
        end
        while (!fin && c < 8 * n + 40) begin
            if (c > 0) @(negedge clk);
            case (mode)
                0: out_ready_i = 1'b1;
                1: out_ready_i = c[0];
                default: begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    out_ready_i = lfsr[0];
                end
            endcase
            if (poke && c == 3) begin
                start_i = 1'b1;
                len_i   = LEN_W'(5);
            end else begin
                start_i = 1'b0;
            end
            #1;
            if (err_o) saw_err = 1;
            if (stalled)
                chk(out_valid_o && out_data_o == held, "R6", int'(out_data_o), int'(held));
            stalled = 0;
            if (out_valid_o) begin
                if (out_ready_i) begin
                    chk(out_data_o == exp_byte(k, n), req_of(k, n),
                        int'(out_data_o), int'(exp_byte(k, n)));
                    chk(out_last_o == (k == n - 1), "R4", int'(out_last_o), int'(k == n - 1));
                    k++;
                end else begin
                    stalled = 1;
                    held = out_data_o;
                end
            end
            if (done_o) begin
                chk(k == n, "R3", k, n);
                chk(int'(count_o) == n, "R7", int'(count_o), n);
                fin = 1;
            end
            c++;
        end
        start_i = 1'b0;
        chk(fin, "R7", int'(fin), 1);
        if (poke) chk(!saw_err, "R8", int'(saw_err), 0);
        @(negedge clk); #1;
        chk(done_o == 1'b0 && busy_o == 1'b0, "R7", int'({done_o, busy_o}), 0);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!out_valid_o && !out_last_o && !busy_o && !err_o && !done_o, "R9",
            int'({out_valid_o, out_last_o, busy_o, err_o, done_o}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!out_valid_o && !busy_o, "R9", int'({out_valid_o, busy_o}), 0);
        for (int m = 0; m < 3; m++)
            for (int n = 0; n <= 40; n++)
                run_unit(n, m, 1'b0);
        run_unit(7, 0, 1'b1);
        run_unit(20, 2, 1'b1);
        run_unit(300, 2, 1'b0);
        run_unit(65535, 0, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule